// File: doc/BRIEF.md
# Strobe-Captured Read Deserializer

This block receives read data from an external device that sends a strobe along with its data. Pins are sampled on the strobe edges: on the rising edge only in single-rate mode, or on both edges in double-rate mode. The block packs the beats into wide words, one word per core-clock cycle. The core clock runs at one, two or four times the external strobe period, set by `RATE`. Finished words cross into the core clock domain through a small asynchronous FIFO.

When the core issues a read, it raises one read-enable bit for each external clock slot it expects to fill. After a fixed latency, the block returns that same bit pattern as per-slot valid flags, together with the next word from the FIFO. The latency is the programmed read latency plus a margin, rounded up to whole core cycles.

Enables are honoured only after the core sees a fresh rising edge on the interface-locked input. This holds the block off until the capture path has settled.

Top module: `strobe_rd_deser`

## Requirements
- R1: Each core word holds `RATE` × (2 in double-rate, 1 in single-rate) beats of `PIN_W` bits. Beat b of a frame sits in bits `[b*PIN_W +: PIN_W]`, with beat 0 at the least significant end. In double-rate mode, the beat sampled on a rising strobe edge takes the even slot and the beat on the following falling edge takes the next odd slot.
- R2: Framing starts at strobe-domain reset. Every `RATE` strobe periods make one word, and words leave the block in the order they were captured.
- R3: A read-enable pattern driven before core edge k shows up unchanged on `rd_valid` after edge k+D−1. Here D = max(1, ceil((`RD_LAT`+`MARGIN`)/`RATE`)), which is 2 for the default parameters. Before that edge, `rd_valid` is still zero.
- R4: Each core cycle with nonzero `rd_valid` presents exactly one FIFO word on `rd_data`. Consecutive valid cycles present consecutive words.
- R5: `rd_data` is all zeros in any cycle where `rd_valid` is zero. It is also all zeros when a valid pattern arrives while the FIFO is empty.
- R6: Enables are ignored while the lock gate is closed. Ignored enables produce no valid bits and consume no FIFO word. The gate opens one cycle after a rising edge of `if_locked` is sampled, and it closes on the cycle after `if_locked` is sampled low.
- R7: Core reset clears `rd_valid`, `rd_data` and the latency pipeline. Strobe reset together with core reset empties the FIFO. After reset, the gate stays closed even if `if_locked` is held high, and it opens only on a new rising edge.
- R8: A word that completes while the FIFO is full is dropped, and it sets a sticky `ovfl` flag that the core domain can see. Only resets clear the flag.
- R9: The FIFO write pointer's Gray code changes by at most one bit per strobe step. It does not advance while the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core clock |
| rst_n | input | 1 | Core-domain synchronous active-low reset |
| strb_clk | input | 1 | Forwarded strobe from the external device |
| strb_rst_n | input | 1 | Strobe-domain synchronous active-low reset, sampled on strobe edges |
| pin_data | input | PIN_W | Data pins, centred on the strobe edges |
| if_locked | input | 1 | Interface-locked indication, synchronous to `clk_core` |
| rd_en | input | RATE | Per-slot read-enable pattern |
| rd_valid | output | RATE | Delayed per-slot valid pattern |
| rd_data | output | PIN_W×RATE×(DDR?2:1) | Core word presented with `rd_valid` |
| ovfl | output | 1 | Sticky FIFO overflow flag, core domain |

## Verification
The assertions check on every cycle that:
- data is zero whenever no slot is valid;
- a low lock input always empties the head of the latency pipeline two cycles later;
- the overflow flag never drops outside reset;
- the write pointer moves one Gray bit at a time and holds while the FIFO is full.

Only the bench scenarios can show the behaviours that need known stimulus:
- the beat ordering inside a word;
- the exact latency to the cycle;
- that gated enables leave the FIFO untouched;
- that a word is dropped on overflow;
- that the gate needs a fresh lock edge after reset.

// File: rtl/rdsr_pkg.sv
// Package: shared helper functions for the strobe-captured read deserializer.
// Assumes all arguments are small positive integers known at elaboration.
package rdsr_pkg;

    // Beats captured per strobe period: two in double-rate mode, one otherwise.
    function automatic int unsigned beats_per_period(input bit ddr);
        return ddr ? 2 : 1;
    endfunction

    // Latency in core cycles: (lat + margin) / rate rounded up, never below 1.
    function automatic int unsigned lat_core_cycles(input int unsigned lat,
                                                    input int unsigned margin,
                                                    input int unsigned rate);
        int unsigned c;
        c = (lat + margin + rate - 1) / rate;
        return (c == 0) ? 1 : c;
    endfunction

    // Width of a counter that counts 0..n-1 (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rdsr_capture.sv
// Module: strobe-domain capture and framing.
// Registers each rising-edge beat. On each falling strobe edge it combines
// that beat with the live falling-edge beat (double-rate) or uses it alone
// (single-rate), shifting toward the LSB so the earliest beat ends at bit 0.
// Assumes pin_data is stable around both strobe edges. The push strobe and
// word are combinational and must be consumed on the same falling edge.
module rdsr_capture
    import rdsr_pkg::*;
#(
    parameter int unsigned PIN_W = 8,
    parameter int unsigned RATE  = 4,
    parameter bit          DDR   = 1'b1
) (
    input  logic                                             strb_clk,
    input  logic                                             strb_rst_n,
    input  logic [PIN_W-1:0]                                 pin_data,
    output logic                                             push,
    output logic [PIN_W*beats_per_period(DDR)*RATE-1:0]      push_word
);
    localparam int unsigned BPP    = beats_per_period(DDR);
    localparam int unsigned CHUNK  = PIN_W * BPP;
    localparam int unsigned WORD_W = CHUNK * RATE;
    localparam int unsigned CNT_W  = cnt_width(RATE);

    logic [PIN_W-1:0] rise_q;
    logic [CHUNK-1:0] chunk;

    // Hold the beat sampled on the rising strobe edge.
    always_ff @(posedge strb_clk) begin
        if (!strb_rst_n) rise_q <= '0;
        else             rise_q <= pin_data;
    end

    generate
        if (DDR) begin : g_ddr
            // Rising beat in the lower slot, falling beat just above it.
            assign chunk = {pin_data, rise_q};
        end else begin : g_sdr
            assign chunk = rise_q;
        end

        if (RATE == 1) begin : g_r1
            // Each strobe period is a complete word.
            assign push      = strb_rst_n;
            assign push_word = chunk;
        end else begin : g_rn
            logic [CNT_W-1:0]  cnt_q;
            logic [WORD_W-1:0] acc_q;
            logic [WORD_W-1:0] acc_next;

            assign acc_next  = {chunk, acc_q[WORD_W-1:CHUNK]};
            assign push      = strb_rst_n && (cnt_q == CNT_W'(RATE - 1));
            assign push_word = acc_next;

            // Shift chunks toward the LSB and count periods within a frame.
            always_ff @(negedge strb_clk) begin
                if (!strb_rst_n) begin
                    cnt_q <= '0;
                    acc_q <= '0;
                end else begin
                    acc_q <= acc_next;
                    cnt_q <= (cnt_q == CNT_W'(RATE - 1)) ? '0 : cnt_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rdsr_afifo.sv
// Module: asynchronous FIFO with Gray-coded pointers.
// Writes on the falling edge of wclk; reads on the rising edge of rclk.
// Each side passes its Gray pointer to the other through two flops.
// A write attempted while full is dropped and sets a sticky overflow flag,
// which is synchronised into the read domain. Assumes AW >= 2.
module rdsr_afifo #(
    parameter int unsigned W  = 64,
    parameter int unsigned AW = 3
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    output logic          wr_full,
    output logic [AW:0]   wr_bin,
    output logic [AW:0]   wr_gray,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    output logic          rd_empty,
    output logic          ovfl_r
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [W-1:0]  mem [DEPTH];
    logic [AW:0]   rd_bin, rd_gray;
    logic [AW:0]   rg_s1, rg_s2;
    logic [AW:0]   wg_s1, wg_s2;
    logic          ovfl_w;
    logic          ov_s1, ov_s2;
    logic [AW:0]   wr_bin_nx, rd_bin_nx;

    assign wr_full   = (wr_gray == {~rg_s2[AW:AW-1], rg_s2[AW-2:0]});
    assign wr_bin_nx = wr_bin + 1'b1;
    assign rd_empty  = (rd_gray == wg_s2);
    assign rd_bin_nx = rd_bin + 1'b1;
    assign rdata     = mem[rd_bin[AW-1:0]];
    assign ovfl_r    = ov_s2;

    // Write storage; no reset, so contents are qualified by the pointers.
    always_ff @(negedge wclk) begin
        if (wr && !wr_full) mem[wr_bin[AW-1:0]] <= wdata;
    end

    // Advance the write pointer, or record an overflow.
    always_ff @(negedge wclk) begin
        if (!wrst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
            ovfl_w  <= 1'b0;
        end else if (wr) begin
            if (wr_full) begin
                ovfl_w <= 1'b1;
            end else begin
                wr_bin  <= wr_bin_nx;
                wr_gray <= wr_bin_nx ^ (wr_bin_nx >> 1);
            end
        end
    end

    // Bring the read pointer into the write domain.
    always_ff @(negedge wclk) begin
        if (!wrst_n) begin
            rg_s1 <= '0;
            rg_s2 <= '0;
        end else begin
            rg_s1 <= rd_gray;
            rg_s2 <= rg_s1;
        end
    end

    // Advance the read pointer on a pop from a non-empty FIFO.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else if (rd && !rd_empty) begin
            rd_bin  <= rd_bin_nx;
            rd_gray <= rd_bin_nx ^ (rd_bin_nx >> 1);
        end
    end

    // Bring the write pointer and the overflow flag into the read domain.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            wg_s1 <= '0;
            wg_s2 <= '0;
            ov_s1 <= 1'b0;
            ov_s2 <= 1'b0;
        end else begin
            wg_s1 <= wr_gray;
            wg_s2 <= wg_s1;
            ov_s1 <= ovfl_w;
            ov_s2 <= ov_s1;
        end
    end

endmodule

// File: rtl/rdsr_lat_pipe.sv
// Module: read-latency pipeline, one RATE-bit enable pattern per core cycle.
// DEPTH stages; the tail is the delayed pattern. pre_tail is the value that
// the tail loads on the next edge, so the data path can pop in step with it.
module rdsr_lat_pipe #(
    parameter int unsigned RATE  = 4,
    parameter int unsigned DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RATE-1:0] en_in,
    output logic [RATE-1:0] head,
    output logic [RATE-1:0] pre_tail,
    output logic [RATE-1:0] tail
);
    logic [RATE-1:0] stg [DEPTH];

    // Shift the accepted enable pattern down the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
            stg[0] <= en_in;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign head = stg[0];
    assign tail = stg[DEPTH-1];

    generate
        if (DEPTH == 1) begin : g_d1
            assign pre_tail = en_in;
        end else begin : g_dn
            assign pre_tail = stg[DEPTH-2];
        end
    endgenerate

endmodule

// File: rtl/strobe_rd_deser.sv
// Module: top of the strobe-captured read deserializer.
// Captures strobe-aligned beats into core words, buffers them in an
// asynchronous FIFO, delays lock-gated read enables by the rounded
// latency, and pops one word for each valid core cycle.
// Assumes if_locked and rd_en are synchronous to clk_core.
module strobe_rd_deser
    import rdsr_pkg::*;
#(
    parameter int unsigned PIN_W   = 8,
    parameter int unsigned RATE    = 4,
    parameter bit          DDR     = 1'b1,
    parameter int unsigned RD_LAT  = 6,
    parameter int unsigned MARGIN  = 1,
    parameter int unsigned FIFO_AW = 3
) (
    input  logic                                        clk_core,
    input  logic                                        rst_n,
    input  logic                                        strb_clk,
    input  logic                                        strb_rst_n,
    input  logic [PIN_W-1:0]                            pin_data,
    input  logic                                        if_locked,
    input  logic [RATE-1:0]                             rd_en,
    output logic [RATE-1:0]                             rd_valid,
    output logic [PIN_W*beats_per_period(DDR)*RATE-1:0] rd_data,
    output logic                                        ovfl
);
    localparam int unsigned WORD_W = PIN_W * beats_per_period(DDR) * RATE;
    localparam int unsigned LAT_D  = lat_core_cycles(RD_LAT, MARGIN, RATE);

    logic              cap_push;
    logic [WORD_W-1:0] cap_word;
    logic              wr_full;
    logic [FIFO_AW:0]  wr_bin, wr_gray;
    logic [WORD_W-1:0] fifo_head;
    logic              fifo_empty;
    logic              pop;
    logic              gate_q, lock_prev_q;
    logic [RATE-1:0]   en_acc;
    logic [RATE-1:0]   lat_head, lat_pre, lat_tail;
    logic [WORD_W-1:0] data_q;

    rdsr_capture #(.PIN_W(PIN_W), .RATE(RATE), .DDR(DDR)) u_cap (
        .strb_clk   (strb_clk),
        .strb_rst_n (strb_rst_n),
        .pin_data   (pin_data),
        .push       (cap_push),
        .push_word  (cap_word)
    );

    rdsr_afifo #(.W(WORD_W), .AW(FIFO_AW)) u_fifo (
        .wclk     (strb_clk),
        .wrst_n   (strb_rst_n),
        .wr       (cap_push),
        .wdata    (cap_word),
        .wr_full  (wr_full),
        .wr_bin   (wr_bin),
        .wr_gray  (wr_gray),
        .rclk     (clk_core),
        .rrst_n   (rst_n),
        .rd       (pop),
        .rdata    (fifo_head),
        .rd_empty (fifo_empty),
        .ovfl_r   (ovfl)
    );

    // Lock gate: opens on a fresh rising lock edge, closes when lock drops.
    always_ff @(posedge clk_core) begin
        if (!rst_n) begin
            gate_q      <= 1'b0;
            lock_prev_q <= 1'b1;
        end else begin
            lock_prev_q <= if_locked;
            if (!if_locked)        gate_q <= 1'b0;
            else if (!lock_prev_q) gate_q <= 1'b1;
        end
    end

    assign en_acc = gate_q ? rd_en : '0;

    rdsr_lat_pipe #(.RATE(RATE), .DEPTH(LAT_D)) u_pipe (
        .clk      (clk_core),
        .rst_n    (rst_n),
        .en_in    (en_acc),
        .head     (lat_head),
        .pre_tail (lat_pre),
        .tail     (lat_tail)
    );

    assign pop = (|lat_pre) && !fifo_empty;

    // Output word: the FIFO head on a pop, otherwise zero.
    always_ff @(posedge clk_core) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= pop ? fifo_head : '0;
    end

    assign rd_valid = lat_tail;
    assign rd_data  = data_q;

endmodule

// File: rtl/rdsr_chk.sv
// Checker: cycle-by-cycle properties of strobe_rd_deser, attached by bind.
module rdsr_chk #(
    parameter int unsigned RATE   = 4,
    parameter int unsigned WORD_W = 64,
    parameter int unsigned AW     = 3
) (
    input logic              clk_core,
    input logic              rst_n,
    input logic              strb_clk,
    input logic              strb_rst_n,
    input logic              if_locked,
    input logic [RATE-1:0]   rd_valid,
    input logic [WORD_W-1:0] rd_data,
    input logic              ovfl,
    input logic [RATE-1:0]   lat_head,
    input logic              wr_full,
    input logic              wr_push,
    input logic [AW:0]       wr_bin,
    input logic [AW:0]       wr_gray
);
    // R5
    zero_data_chk: assert property (@(posedge clk_core) disable iff (!rst_n)
        (rd_valid == '0) |-> (rd_data == '0));

    // R6
    lock_gate_chk: assert property (@(posedge clk_core) disable iff (!rst_n)
        !if_locked |=> ##1 (lat_head == '0));

    // R7
    reset_clear_chk: assert property (@(posedge clk_core)
        !rst_n |=> (rd_valid == '0 && rd_data == '0));

    // R8
    sticky_ovfl_chk: assert property (@(posedge clk_core) disable iff (!rst_n)
        ovfl |=> ovfl);

    // R9
    gray_step_chk: assert property (@(negedge strb_clk) disable iff (!strb_rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    // R9
    full_hold_chk: assert property (@(negedge strb_clk) disable iff (!strb_rst_n)
        (wr_full && wr_push) |=> $stable(wr_bin));

endmodule

bind strobe_rd_deser rdsr_chk #(.RATE(RATE), .WORD_W(WORD_W), .AW(FIFO_AW)) u_chk (
    .clk_core   (clk_core),
    .rst_n      (rst_n),
    .strb_clk   (strb_clk),
    .strb_rst_n (strb_rst_n),
    .if_locked  (if_locked),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .ovfl       (ovfl),
    .lat_head   (lat_head),
    .wr_full    (wr_full),
    .wr_push    (cap_push),
    .wr_bin     (wr_bin),
    .wr_gray    (wr_gray)
);

// File: tb/sim_strobe_rd_deser.sv
`timescale 1ns/1ps
module sim_strobe_rd_deser;
    localparam int unsigned PIN_W   = 8;
    localparam int unsigned RATE    = 4;
    localparam bit          DDR     = 1'b1;
    localparam int unsigned RD_LAT  = 6;
    localparam int unsigned MARGIN  = 1;
    localparam int unsigned FIFO_AW = 3;
    localparam int unsigned BEATS   = RATE * (DDR ? 2 : 1);
    localparam int unsigned WORD_W  = PIN_W * BEATS;
    localparam int unsigned DLAT    = ((RD_LAT + MARGIN + RATE - 1) / RATE) == 0 ? 1
                                    : ((RD_LAT + MARGIN + RATE - 1) / RATE);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strb = 1'b0;
    logic              strb_rst_n = 1'b0;
    logic [PIN_W-1:0]  pins = '0;
    logic              lock = 1'b0;
    logic [RATE-1:0]   rd_en = '0;
    logic [RATE-1:0]   rd_valid;
    logic [WORD_W-1:0] rd_data;
    logic              ovfl;

    int n_chk = 0;
    int n_bad = 0;
    logic [WORD_W-1:0] exp_q[$];

    strobe_rd_deser #(.PIN_W(PIN_W), .RATE(RATE), .DDR(DDR), .RD_LAT(RD_LAT),
                      .MARGIN(MARGIN), .FIFO_AW(FIFO_AW)) u0 (
        .clk_core(clk), .rst_n(rst_n), .strb_clk(strb), .strb_rst_n(strb_rst_n),
        .pin_data(pins), .if_locked(lock), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_data(rd_data), .ovfl(ovfl));

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [WORD_W-1:0] act,
                         input logic [WORD_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO-side check FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One strobe period with the given rising and falling beats.
    task automatic strobe_cycle(input logic [PIN_W-1:0] br, input logic [PIN_W-1:0] bf);
        pins = br;  #1.25;
        strb = 1'b1; #1.25;
        pins = bf;  #1.25;
        strb = 1'b0; #1.25;
    endtask

    // Send n words; beat b of word w carries seed + w*BEATS + b.
    task automatic send_words(input int n, input int seed);
        for (int w = 0; w < n; w++) begin
            logic [WORD_W-1:0] word = '0;
            for (int j = 0; j < RATE; j++) begin
                logic [PIN_W-1:0] br = PIN_W'(seed + w*BEATS + 2*j);
                logic [PIN_W-1:0] bf = PIN_W'(seed + w*BEATS + 2*j + 1);
                word[(2*j)*PIN_W +: PIN_W]   = br;
                word[(2*j+1)*PIN_W +: PIN_W] = bf;
                strobe_cycle(br, bf);
            end
            exp_q.push_back(word);
        end
        pins = '0;
        repeat (6) @(negedge clk);
    endtask

    // Drive pat for n cycles and check valid and data at every negedge.
    task automatic read_run(input logic [RATE-1:0] pat, input int n,
                            input bit accepted, input string req);
        for (int c = 0; c <= n + DLAT; c++) begin
            @(negedge clk);
            if (c == DLAT - 1)
                check({req, "/R3 before latency"}, WORD_W'(rd_valid), '0);
            if (c >= DLAT && c < n + DLAT) begin
                logic [WORD_W-1:0] ed = '0;
                if (accepted && exp_q.size() > 0) ed = exp_q.pop_front();
                check({req, " valid"}, WORD_W'(rd_valid), accepted ? WORD_W'(pat) : '0);
                check({req, " data"}, rd_data, ed);
            end
            if (c == n + DLAT) begin
                check("R5 valid idle", WORD_W'(rd_valid), '0);
                check("R5 data zero", rd_data, '0);
            end
            rd_en = (c < n) ? pat : '0;
        end
        rd_en = '0;
    endtask

    task automatic do_resets();
        rst_n = 1'b0;
        strb_rst_n = 1'b0;
        for (int i = 0; i < 3; i++) strobe_cycle('0, '0);
        strb_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        exp_q.delete();
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        check("R7 reset valid", WORD_W'(rd_valid), '0);
        check("R7 reset data", rd_data, '0);
        check("R8 reset ovfl", WORD_W'(ovfl), '0);
    endtask

    task automatic t_lock_gate();
        send_words(1, 8'h10);
        read_run('1, 2, 1'b0, "R6 gated");
        lock = 1'b1;
        repeat (2) @(negedge clk);
        read_run('1, 1, 1'b1, "R6/R1 after lock");
    endtask

    task automatic t_multi();
        send_words(3, 8'h40);
        read_run('1, 3, 1'b1, "R2/R4 consecutive");
    endtask

    task automatic t_partial();
        send_words(1, 8'h80);
        read_run(RATE'(4'b0101), 1, 1'b1, "R3 partial");
    endtask

    task automatic t_underflow();
        read_run(RATE'(4'b0011), 1, 1'b1, "R5 empty");
    endtask

    task automatic t_overflow();
        send_words((1 << FIFO_AW) + 1, 8'hA0);
        check("R8 ovfl set", WORD_W'(ovfl), WORD_W'(1));
        repeat (5) @(negedge clk);
        check("R8 ovfl sticky", WORD_W'(ovfl), WORD_W'(1));
        // R8: the dropped ninth word must not appear; eight come out in order.
        void'(exp_q.pop_back());
        read_run('1, 1 << FIFO_AW, 1'b1, "R8 kept words");
        read_run('1, 1, 1'b1, "R8 dropped word");
    endtask

    task automatic t_reset_relock();
        do_resets();
        check("R7 ovfl cleared", WORD_W'(ovfl), '0);
        read_run('1, 1, 1'b0, "R7 gate closed");
        lock = 1'b0;
        repeat (2) @(negedge clk);
        lock = 1'b1;
        repeat (2) @(negedge clk);
        read_run('1, 1, 1'b1, "R7 fifo emptied");
        send_words(1, 8'hC0);
        read_run('1, 1, 1'b1, "R2 reframed");
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("Watchdog FAIL: run did not complete (actual hung, expected done)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_resets();
        t_reset_state();
        t_lock_gate();
        t_multi();
        t_partial();
        t_underflow();
        t_overflow();
        t_reset_relock();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule